// File: doc/BRIEF.md
# Dual-Channel Serial ADC Frame Capture

This block runs a serial-output converter that delivers two 14-bit channel results inside one chip-select frame. For each sample, it pulls the conversion-start line low for a short time. It then waits out the conversion time, selects the converter and produces 28 serial clocks. The first 14 data bits form channel A and the last 14 form channel B, each sent most significant bit first. Each word is turned into a signed result. Any raw value above a programmable threshold has the full-scale value subtracted from it, so the output is negative. The two 16-bit results are then offered on a one-cycle strobe together with the slot index of a circular sample store.

Acquisition runs continuously while `run` is high. A sequencer with six states controls the frame:

- `ST_IDLE` moves to `ST_CNV` when `run` is high.
- `ST_CNV` (start pulse) moves to `ST_WAIT` once its timer expires.
- `ST_WAIT` (conversion time) moves to `ST_SCK_LO` once its timer expires.
- `ST_SCK_LO` (clock low; data sampled in its last cycle) moves to `ST_SCK_HI`.
- `ST_SCK_HI` returns to `ST_SCK_LO` for the next bit, or goes to `ST_DONE` after the 28th bit.
- `ST_DONE` (chip select released, strobe issued) goes back to `ST_CNV` while `run` holds, or to `ST_IDLE` otherwise.

All phase lengths are parameters counted in system clock cycles. The defaults assume a 100 MHz clock.

Top module: `adc_frame_capture`

## Requirements
- R1: After reset and while idle, `adc_cnv_n`, `adc_cs_n` and `adc_sck` are high, while `busy`, `smp_valid`, `smp_idx` and `smp_count` are zero.
- R2: Each frame begins with `adc_cnv_n` low for exactly CNV_LOW cycles (default 2, i.e. 20 ns) while `adc_cs_n` stays high.
- R3: From the cycle `adc_cnv_n` returns high, exactly CONV_WAIT cycles (default 65) pass before `adc_cs_n` goes low.
- R4: While `adc_cs_n` is low, exactly 28 `adc_sck` low pulses occur. Each is SCK_LO cycles low, and between pulses the clock is SCK_HI cycles high. `adc_sck` is high whenever `adc_cs_n` is high.
- R5: `adc_sdo` is sampled in the last cycle of each low phase. Bits 0..13 of the frame form channel A and bits 14..27 form channel B, each MSB first.
- R6: A 14-bit word w becomes w when w <= THRESH (default 8191), and w - FULL (default 16384) otherwise. The result is a 16-bit two's complement value, so 8191 stays 8191, 8192 becomes -8192 and 16383 becomes -1.
- R7: Each channel's result depends only on its own 14 bits.
- R8: `smp_valid` is high for exactly one cycle per frame: the first cycle in which `adc_cs_n` is high again. In that cycle it presents both results.
- R9: In the strobe cycle, `smp_idx` is the slot for that sample. The first sample uses slot 0, and each later sample uses the next slot modulo DEPTH (default 16). `smp_count` rises by one at the end of each strobe cycle.
- R10: When `run` falls during a frame, that frame still completes and is delivered. No further frame starts, both select lines stay high and `smp_count` holds.
- R11: `busy` is high from the start pulse through the strobe cycle, and it is high whenever either select line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Continuous acquisition enable, sampled at frame boundaries |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cnv_n | output | 1 | Conversion start, active low |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sck | output | 1 | Serial clock, idles high |
| busy | output | 1 | A frame is in progress |
| smp_valid | output | 1 | One-cycle result strobe |
| smp_a | output | 16 | Channel A signed result |
| smp_b | output | 16 | Channel B signed result |
| smp_idx | output | 4 | Circular store slot for this sample |
| smp_count | output | 32 | Number of completed frames |

## Verification
A wrong phase timer or state transition shows up within one frame, as a start pulse, conversion gap or clock phase of the wrong length at the select pins. A wrong bit counter shows up at the next chip-select release, as a pulse count other than 28. A misplaced channel boundary or a wrong fixup corrupts the strobed results of the very frame in which it occurs, and boundary words 8191, 8192, 0 and 16383 expose an off-by-one threshold. Index or counter errors appear at the first strobe or at the sixteenth wrap. A faulty stop rule shows up as an extra start pulse right after the last strobe.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNV,
        ST_WAIT,
        ST_SCK_LO,
        ST_SCK_HI,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/adc_seq.sv
module adc_seq
    import adc_cap_pkg::*;
#(
    parameter int CNV_LOW    = 2,
    parameter int CONV_WAIT  = 65,
    parameter int SCK_LO     = 6,
    parameter int SCK_HI     = 6,
    parameter int FRAME_BITS = 28,
    parameter int BIT_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic             cnv_n,
    output logic             cs_n,
    output logic             sck,
    output logic             busy,
    output logic             frame_done,
    output logic             shift_en,
    output logic [BIT_W-1:0] bit_pos
);
    localparam int M1   = (CNV_LOW > CONV_WAIT) ? CNV_LOW : CONV_WAIT;
    localparam int M2   = (SCK_LO > SCK_HI) ? SCK_LO : SCK_HI;
    localparam int MAXT = (M1 > M2) ? M1 : M2;
    localparam int TW   = $clog2(MAXT + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    seq_state_t       state, nxt;
    logic [TW-1:0]    tcnt, lim;
    logic             tdone;
    logic [BIT_W-1:0] bitcnt;

    always_comb begin
        unique case (state)
            ST_CNV:    lim = TW'(CNV_LOW);
            ST_WAIT:   lim = TW'(CONV_WAIT);
            ST_SCK_LO: lim = TW'(SCK_LO);
            ST_SCK_HI: lim = TW'(SCK_HI);
            default:   lim = TW'(1);
        endcase
    end

    assign tdone = (tcnt == lim - TW'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (run)   nxt = ST_CNV;
            ST_CNV:    if (tdone) nxt = ST_WAIT;
            ST_WAIT:   if (tdone) nxt = ST_SCK_LO;
            ST_SCK_LO: if (tdone) nxt = ST_SCK_HI;
            ST_SCK_HI: if (tdone) nxt = (bitcnt == LAST_BIT) ? ST_DONE : ST_SCK_LO;
            ST_DONE:   nxt = run ? ST_CNV : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tcnt   <= '0;
            bitcnt <= '0;
        end else begin
            state <= nxt;
            tcnt  <= (nxt != state) ? '0 : tcnt + TW'(1);
            if (state == ST_WAIT)
                bitcnt <= '0;
            else if (state == ST_SCK_HI && tdone && bitcnt != LAST_BIT)
                bitcnt <= bitcnt + BIT_W'(1);
        end
    end

    always_comb begin
        cnv_n      = 1'b1;
        cs_n       = 1'b1;
        sck        = 1'b1;
        busy       = 1'b1;
        frame_done = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_CNV:    cnv_n = 1'b0;
            ST_WAIT:   ;
            ST_SCK_LO: begin cs_n = 1'b0; sck = 1'b0; end
            ST_SCK_HI: cs_n = 1'b0;
            ST_DONE:   frame_done = 1'b1;
        endcase
    end

    assign shift_en = (state == ST_SCK_LO) && tdone;
    assign bit_pos  = bitcnt;

    p_cnv_cs_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_n |-> cs_n);
    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sck);
    p_bit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt < BIT_W'(FRAME_BITS));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    p_stop_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !run) |=> !busy);
    p_busy_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnv_n || !cs_n) |-> busy);
endmodule

// File: rtl/adc_chan.sv
module adc_chan #(
    parameter int WORD_W = 14,
    parameter int BASE   = 0,
    parameter int BIT_W  = 5,
    parameter int OUT_W  = 16,
    parameter int THRESH = 8191,
    parameter int FULL   = 16384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [BIT_W-1:0] bit_pos,
    input  logic             din,
    output logic [OUT_W-1:0] result
);
    localparam logic [BIT_W-1:0] FIRST = BIT_W'(BASE);
    localparam logic [BIT_W-1:0] LAST  = BIT_W'(BASE + WORD_W - 1);

    logic [WORD_W-1:0] shreg, word_nxt;
    logic              in_word;
    logic [OUT_W-1:0]  widened;

    assign in_word  = (bit_pos >= FIRST) && (bit_pos <= LAST);
    assign word_nxt = {shreg[WORD_W-2:0], din};
    assign widened  = {{(OUT_W-WORD_W){1'b0}}, word_nxt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            result <= '0;
        end else if (shift_en && in_word) begin
            shreg <= word_nxt;
            if (bit_pos == LAST)
                result <= (word_nxt > WORD_W'(THRESH)) ? widened - OUT_W'(FULL) : widened;
        end
    end

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && bit_pos == LAST) |=> $stable(result));
endmodule

// File: rtl/adc_slot_ctr.sv
module adc_slot_ctr #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    output logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] count
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            count <= '0;
        end else if (frame_done) begin
            idx   <= (idx == TOP) ? '0 : idx + IDX_W'(1);
            count <= count + CNT_W'(1);
        end
    end

    p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= TOP);
    p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> ($stable(idx) && $stable(count)));
endmodule

// File: rtl/adc_frame_capture.sv
module adc_frame_capture #(
    parameter int CNV_LOW   = 2,
    parameter int CONV_WAIT = 65,
    parameter int SCK_LO    = 6,
    parameter int SCK_HI    = 6,
    parameter int WORD_W    = 14,
    parameter int OUT_W     = 16,
    parameter int THRESH    = 8191,
    parameter int FULL      = 16384,
    parameter int DEPTH     = 16,
    parameter int CNT_W     = 32,
    localparam int NCH        = 2,
    localparam int FRAME_BITS = NCH * WORD_W,
    localparam int BIT_W      = $clog2(FRAME_BITS),
    localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             adc_sdo,
    output logic             adc_cnv_n,
    output logic             adc_cs_n,
    output logic             adc_sck,
    output logic             busy,
    output logic             smp_valid,
    output logic [OUT_W-1:0] smp_a,
    output logic [OUT_W-1:0] smp_b,
    output logic [IDX_W-1:0] smp_idx,
    output logic [CNT_W-1:0] smp_count
);
    logic             shift_en, frame_done;
    logic [BIT_W-1:0] bit_pos;
    logic [OUT_W-1:0] chan_res [NCH];

    adc_seq #(
        .CNV_LOW(CNV_LOW), .CONV_WAIT(CONV_WAIT), .SCK_LO(SCK_LO),
        .SCK_HI(SCK_HI), .FRAME_BITS(FRAME_BITS), .BIT_W(BIT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run),
        .cnv_n(adc_cnv_n), .cs_n(adc_cs_n), .sck(adc_sck), .busy(busy),
        .frame_done(frame_done), .shift_en(shift_en), .bit_pos(bit_pos)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        adc_chan #(
            .WORD_W(WORD_W), .BASE(c * WORD_W), .BIT_W(BIT_W),
            .OUT_W(OUT_W), .THRESH(THRESH), .FULL(FULL)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
            .bit_pos(bit_pos), .din(adc_sdo), .result(chan_res[c])
        );
    end

    adc_slot_ctr #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
        .idx(smp_idx), .count(smp_count)
    );

    assign smp_valid = frame_done;
    assign smp_a     = chan_res[0];
    assign smp_b     = chan_res[1];

    p_valid_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (adc_cs_n && !$past(adc_cs_n)));
endmodule

// File: tb/adc_frame_capture_test.sv
module adc_frame_capture_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNV_LOW = 2, CONV_WAIT = 65, SCK_LO = 6, SCK_HI = 6;
    localparam int DEPTH = 16;

    logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, adc_sdo = 1'b0;
    logic adc_cnv_n, adc_cs_n, adc_sck, busy, smp_valid;
    logic [15:0] smp_a, smp_b;
    logic [3:0]  smp_idx;
    logic [31:0] smp_count;

    int checks = 0, errors = 0, started = 0, delivered = 0, cnv_falls = 0;
    int adc_a[$], adc_b[$], exp_a[$], exp_b[$];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_frame_capture uut (
        .clk(clk), .rst_n(rst_n), .run(run), .adc_sdo(adc_sdo),
        .adc_cnv_n(adc_cnv_n), .adc_cs_n(adc_cs_n), .adc_sck(adc_sck),
        .busy(busy), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
        .smp_idx(smp_idx), .smp_count(smp_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int fix(input int v);
        return (v > 8191) ? v - 16384 : v;
    endfunction

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // converter model: one frame per chip-select assertion
    initial begin
        forever begin
            logic [27:0] frame;
            int a, b;
            @(negedge adc_cs_n);
            started++;
            a = (adc_a.size() > 0) ? adc_a.pop_front() : 0;
            b = (adc_b.size() > 0) ? adc_b.pop_front() : 0;
            frame = {a[13:0], b[13:0]};
            adc_sdo = frame[27];
            for (int k = 1; k < 28; k++) begin
                @(posedge adc_sck);
                adc_sdo = frame[27-k];
            end
        end
    end

    // scoreboard monitor: R5 R6 R7 R9
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && smp_valid) begin
                if (exp_a.size() == 0) begin
                    chk(0, "R8", "unexpected strobe", 1, 0);
                end else begin
                    int ea, eb;
                    ea = exp_a.pop_front();
                    eb = exp_b.pop_front();
                    chk(int'($signed(smp_a)) == ea, "R5/R6", "channel A", int'($signed(smp_a)), ea);
                    chk(int'($signed(smp_b)) == eb, "R5/R7", "channel B", int'($signed(smp_b)), eb);
                    chk(int'(smp_idx) == delivered % DEPTH, "R9", "slot index", int'(smp_idx), delivered % DEPTH);
                    chk(int'(smp_count) == delivered, "R9", "count at strobe", int'(smp_count), delivered);
                end
                delivered++;
            end
        end
    end

    // timing monitor: R2 R3 R4 R8 R11
    initial begin
        logic p_cnv = 1, p_cs = 1, p_sck = 1, p_val = 0;
        int cnvlow = 0, gap = 0, run_len = 0, falls = 0;
        bit gap_on = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!adc_cnv_n) cnvlow++;
                if (!adc_cnv_n && p_cnv) begin
                    cnv_falls++;
                    chk(busy, "R11", "busy at start pulse", busy, 1);
                    chk(adc_cs_n, "R2", "cs high during start", adc_cs_n, 1);
                end
                if (adc_cnv_n && !p_cnv) begin
                    chk(cnvlow == CNV_LOW, "R2", "start pulse width", cnvlow, CNV_LOW);
                    cnvlow = 0; gap = 1; gap_on = 1;
                end else if (gap_on && adc_cs_n) gap++;
                if (gap_on && !adc_cs_n) begin
                    chk(gap == CONV_WAIT, "R3", "conversion gap", gap, CONV_WAIT);
                    chk(busy, "R11", "busy at select", busy, 1);
                    gap_on = 0; falls = 0;
                end
                if (adc_sck == p_sck) run_len++;
                else begin
                    if (!p_sck)
                        chk(run_len == SCK_LO, "R4", "clock low phase", run_len, SCK_LO);
                    else if (!adc_cs_n && !p_cs)
                        chk(run_len == SCK_HI, "R4", "clock high phase", run_len, SCK_HI);
                    run_len = 1;
                end
                if (!adc_cs_n && p_sck && !adc_sck) falls++;
                if (adc_cs_n && !p_cs)
                    chk(falls == 28, "R4", "clocks per frame", falls, 28);
                if (smp_valid)
                    chk(adc_cs_n && !p_cs, "R8", "strobe at release", int'(adc_cs_n && !p_cs), 1);
                if (p_val)
                    chk(!smp_valid, "R8", "strobe width", smp_valid, 0);
                p_cnv = adc_cnv_n; p_cs = adc_cs_n; p_sck = adc_sck; p_val = smp_valid;
            end
        end
    end

    task automatic push_frame(input int a, input int b);
        adc_a.push_back(a); adc_b.push_back(b);
        exp_a.push_back(fix(a)); exp_b.push_back(fix(b));
    endtask

    // run until the given frame number has begun, drop run mid-frame (R10)
    task automatic run_until(input int total);
        int cnt_hold, falls_hold;
        @(negedge clk); run = 1'b1;
        wait (started == total);
        repeat (20) @(negedge clk);
        run = 1'b0;
        wait (!busy);
        @(negedge clk);
        chk(delivered == total, "R10", "last frame delivered", delivered, total);
        chk(exp_a.size() == 0, "R10", "pending results", exp_a.size(), 0);
        cnt_hold = int'(smp_count); falls_hold = cnv_falls;
        chk(cnt_hold == total, "R9", "count after stop", cnt_hold, total);
        repeat (300) @(negedge clk);
        chk(cnv_falls == falls_hold, "R10", "no new start pulse", cnv_falls, falls_hold);
        chk(int'(smp_count) == cnt_hold, "R10", "count holds", int'(smp_count), cnt_hold);
        chk(adc_cnv_n && adc_cs_n && !busy, "R10", "lines idle", int'({adc_cnv_n, adc_cs_n, busy}), 6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "WD", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(adc_cnv_n && adc_cs_n && adc_sck, "R1", "lines in reset", int'({adc_cnv_n, adc_cs_n, adc_sck}), 7);
        chk(!busy && !smp_valid, "R1", "flags in reset", int'({busy, smp_valid}), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(adc_cnv_n && adc_cs_n && adc_sck && !busy, "R1", "idle lines", int'({adc_cnv_n, adc_cs_n, adc_sck, busy}), 14);
        chk(smp_idx == 0 && smp_count == 0, "R1", "idle index/count", int'(smp_idx) + int'(smp_count), 0);
        // boundary words for R6, cross patterns for R5 and R7
        push_frame(0, 16383);
        push_frame(8191, 8192);
        push_frame(16383, 0);
        push_frame(14'h1555, 14'h2AAA);
        push_frame(14'h2000, 14'h1FFF);
        run_until(5);
        for (int i = 0; i < 15; i++)
            push_frame((i * 1237 + 77) % 16384, (i * 5003 + 4099) % 16384);
        run_until(20);
        summary();
    end
endmodule